// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a four-wire serial control link: an active-low select, a bit clock, a data input and a data output with its own enable. A host uses it to read and write a 66-byte register space. The space holds two control bytes and a 64-byte buffer of per-channel status and user bits. Every byte of the space is presented as parallel outputs to the rest of the chip.

Every transaction is 24 bit clocks long and is framed by the select line held low. It carries a command byte, a register address byte and one data byte, each sent most significant bit first. The command byte opens with a two-bit device identifier that must read binary 11, followed by a direction bit (1 = write, 0 = read). Its last five bits are ignored. The select, clock and data-in wires are synchronised into the system clock domain, and the serial edges are found there, so the bit clock must run several times slower than the system clock.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, byte 00h reads 83h (crcEn=1, fmtSel=0, ratioSel=0, muteN=1, resetN=1), byte 01h reads 00h, all 64 buffer bytes are 00h, and sdoOe is low.
- R2: A complete 24-clock write with identifier 11 and direction bit 1 stores the data byte at the addressed register. The frame is command, address, data, each MSB first, sampled on rising bit-clock edges.
- R3: A read with identifier 11 and direction bit 0 returns the addressed byte MSB first on sdo. Each bit is updated after a falling bit-clock edge, starting with the falling edge that follows the 16th rising edge, so the host can sample it on the next rising edge.
- R4: sdoOe is high only while read data is being shifted out. It stays low for the whole of a write, and it drops again once the select line goes high.
- R5: A command whose identifier bits are not 11 leaves sdoOe low and does not change any register.
- R6: Writes to addresses 42h to FFh change nothing. Reads from those addresses return 00h.
- R7: A transaction ended by the select line rising before the 24th rising edge does not write.
- R8: Byte 00h drives the outputs as follows: bit 7 is crcEn, bits 6:4 are the format code, bits 3:2 are the clock-ratio code, bit 1 is muteN and bit 0 is resetN. Byte 01h bits 7:4 drive validity[3:0] and bits 3:0 drive fsCode.
- R9: fmtSel is the bitwise OR of byte 00h bits 6:4 and pinFmt. ratioSel is the bitwise OR of byte 00h bits 3:2 and pinRatio.
- R10: The buffer byte at address 02h+k appears on bufBits[8k+7:8k], for k from 0 to 63.
- R11: Exactly one write happens per transaction, after the 24th rising edge. Extra bit clocks after the 24th edge do not shift the stored byte or cause a second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdoOe | output | 1 | Output enable for sdo (low means high impedance) |
| pinFmt | input | 3 | Format code from pins, ORed into fmtSel |
| pinRatio | input | 2 | Clock-ratio code from pins, ORed into ratioSel |
| crcEn | output | 1 | CRC enable bit |
| fmtSel | output | 3 | Effective audio format code |
| ratioSel | output | 2 | Effective clock-ratio code |
| muteN | output | 1 | Active-low mute/power-down bit |
| resetN | output | 1 | Active-low timing reset bit |
| validity | output | 4 | Per-channel validity flags |
| fsCode | output | 4 | Sample-rate code |
| bufBits | output | 512 | Channel-status and user buffer, byte k at [8k+7:8k] |

## Verification
The hardest situations to reach are frames that differ from a clean 24-clock transfer only in their length. One is a write cut short by the select line after 20 bits. The other runs six bit clocks past the 24th edge with ones on the data line. Both stress the frame counter's saturation and the single write strobe. The bench's transfer task takes the bit count as an argument to reach them. A monitor keeps watch on the output enable during every frame, so that mismatched-identifier and out-of-range frames can be shown to leave sdo idle and the registers untouched.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int FIELD_BITS = 8;
  localparam int FRAME_BITS = 3 * FIELD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int CTRL_BYTES = 2;
  localparam logic [1:0] DEV_ID = 2'b11;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wdata;
  } regStb_t;
endpackage

// File: rtl/serial_reg_frame.sv
module serial_reg_frame
  import serial_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [7:0] rdByte,
  output regStb_t    stb,
  output logic       sdoData,
  output logic       sdoOe
);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST  = CNT_W'(FIELD_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(2 * FIELD_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR_END  = CNT_W'(2 * FIELD_BITS);
  localparam logic [CNT_W-1:0] CNT_DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);

  logic [2:0] sclkSync;
  logic [1:0] csSync, sdiSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= 3'b111;
      csSync   <= 2'b11;
      sdiSync  <= 2'b00;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[0], csN};
      sdiSync  <= {sdiSync[0], sdi};
    end
  end

  logic sclkRise, sclkFall, selected, bitIn;
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];
  assign selected = ~csSync[1];
  assign bitIn    = sdiSync[1];

  logic [CNT_W-1:0] bitCnt;
  logic [6:0] shiftIn;
  logic [7:0] nextByte, addrReg, wdataReg, outShift;
  logic [1:0] idReg;
  logic       rwReg, wrPulse, cmdOk;

  assign nextByte = {shiftIn, bitIn};
  assign cmdOk    = (idReg == DEV_ID);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftIn  <= '0;
      addrReg  <= '0;
      wdataReg <= '0;
      outShift <= '0;
      idReg    <= '0;
      rwReg    <= 1'b0;
      wrPulse  <= 1'b0;
      sdoData  <= 1'b0;
      sdoOe    <= 1'b0;
    end else begin
      wrPulse <= 1'b0;
      if (!selected) begin
        bitCnt  <= '0;
        idReg   <= '0;
        rwReg   <= 1'b0;
        sdoOe   <= 1'b0;
        sdoData <= 1'b0;
      end else begin
        if (sclkRise && bitCnt != CNT_FULL) begin
          shiftIn <= nextByte[6:0];
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == CNT_CMD_LAST) begin
            idReg <= nextByte[7:6];
            rwReg <= nextByte[5];
          end
          if (bitCnt == CNT_ADDR_LAST) addrReg <= nextByte;
          if (bitCnt == CNT_DATA_LAST && cmdOk && rwReg) begin
            wrPulse  <= 1'b1;
            wdataReg <= nextByte;
          end
        end
        if (sclkFall) begin
          if (bitCnt == CNT_ADDR_END && cmdOk && !rwReg) begin
            sdoOe    <= 1'b1;
            sdoData  <= rdByte[7];
            outShift <= {rdByte[6:0], 1'b0};
          end else if (bitCnt == CNT_FULL) begin
            sdoOe   <= 1'b0;
            sdoData <= 1'b0;
          end else if (bitCnt > CNT_ADDR_END) begin
            sdoData  <= outShift[7];
            outShift <= {outShift[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign stb.wr    = wrPulse;
  assign stb.addr  = addrReg;
  assign stb.wdata = wdataReg;

  // R4: deselect always releases the output
  a_r4_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !selected |=> !sdoOe);
  // R4: output never enabled during a write frame
  a_r4_no_oe_on_write: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> !rwReg);
  // R5: output only enabled for a matching identifier
  a_r5_oe_needs_id: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> cmdOk);
  // R11: one-cycle strobe
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);
  // R7: strobe only once the full frame has been counted
  a_r7_strobe_after_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> (bitCnt == CNT_FULL || !selected));
endmodule

// File: rtl/serial_reg_file.sv
module serial_reg_file
  import serial_reg_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStb_t                stb,
  input  logic [2:0]             pinFmt,
  input  logic [1:0]             pinRatio,
  output logic [7:0]             rdByte,
  output logic                   crcEn,
  output logic [2:0]             fmtSel,
  output logic [1:0]             ratioSel,
  output logic                   muteN,
  output logic                   resetN,
  output logic [3:0]             validity,
  output logic [3:0]             fsCode,
  output logic [BUF_BYTES*8-1:0] bufBits
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam logic [7:0] CTL0_RST = 8'h83;
  localparam logic [7:0] CTL1_RST = 8'h00;

  logic [7:0] ctl0, ctl1;
  logic [BUF_BYTES-1:0][7:0] bufMem;
  logic [7:0] bufOff;
  logic [IDX_W-1:0] idx;
  logic inBuf;

  assign bufOff = stb.addr - 8'(CTRL_BYTES);
  assign idx    = bufOff[IDX_W-1:0];
  assign inBuf  = (stb.addr >= 8'(CTRL_BYTES)) && (bufOff < 8'(BUF_BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl0 <= CTL0_RST;
      ctl1 <= CTL1_RST;
    end else if (stb.wr) begin
      if (stb.addr == 8'd0) ctl0 <= stb.wdata;
      if (stb.addr == 8'd1) ctl1 <= stb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufMem <= '0;
    end else begin
      for (int k = 0; k < BUF_BYTES; k++) begin
        if (stb.wr && inBuf && idx == IDX_W'(k)) bufMem[k] <= stb.wdata;
      end
    end
  end

  always_comb begin
    rdByte = 8'h00;
    if (stb.addr == 8'd0)      rdByte = ctl0;
    else if (stb.addr == 8'd1) rdByte = ctl1;
    else if (inBuf)            rdByte = bufMem[idx];
  end

  assign crcEn    = ctl0[7];
  assign fmtSel   = ctl0[6:4] | pinFmt;
  assign ratioSel = ctl0[3:2] | pinRatio;
  assign muteN    = ctl0[1];
  assign resetN   = ctl0[0];
  assign validity = ctl1[7:4];
  assign fsCode   = ctl1[3:0];
  assign bufBits  = bufMem;

  // R6: strobes outside the space leave every byte untouched
  a_r6_high_addr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.addr >= 8'(CTRL_BYTES + BUF_BYTES)) |=>
      ($stable(ctl0) && $stable(ctl1) && $stable(bufMem)));
  // R2: control bytes only change on a strobe
  a_r2_ctl_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wr |=> ($stable(ctl0) && $stable(ctl1)));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import serial_reg_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdoOe,
  input  logic [2:0]             pinFmt,
  input  logic [1:0]             pinRatio,
  output logic                   crcEn,
  output logic [2:0]             fmtSel,
  output logic [1:0]             ratioSel,
  output logic                   muteN,
  output logic                   resetN,
  output logic [3:0]             validity,
  output logic [3:0]             fsCode,
  output logic [BUF_BYTES*8-1:0] bufBits
);
  regStb_t    stb;
  logic [7:0] rdByte;

  serial_reg_frame u_frame (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .rdByte(rdByte), .stb(stb), .sdoData(sdo), .sdoOe(sdoOe)
  );

  serial_reg_file #(.BUF_BYTES(BUF_BYTES)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .pinFmt(pinFmt), .pinRatio(pinRatio),
    .rdByte(rdByte), .crcEn(crcEn), .fmtSel(fmtSel), .ratioSel(ratioSel),
    .muteN(muteN), .resetN(resetN), .validity(validity), .fsCode(fsCode),
    .bufBits(bufBits)
  );
endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [2:0] pinFmt = 3'b000;
  logic [1:0] pinRatio = 2'b00;
  logic sdo, sdoOe, crcEn, muteN, resetN;
  logic [2:0] fmtSel;
  logic [1:0] ratioSel;
  logic [3:0] validity, fsCode;
  logic [511:0] bufBits;

  serial_reg_port uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdoOe(sdoOe), .pinFmt(pinFmt), .pinRatio(pinRatio), .crcEn(crcEn),
    .fmtSel(fmtSel), .ratioSel(ratioSel), .muteN(muteN), .resetN(resetN),
    .validity(validity), .fsCode(fsCode), .bufBits(bufBits)
  );

  localparam logic [7:0] WR_CMD  = 8'b1110_0000;
  localparam logic [7:0] RD_CMD  = 8'b1100_0000;
  localparam logic [7:0] BAD_WR  = 8'b1010_0000;
  localparam logic [7:0] BAD_RD  = 8'b1000_0000;

  int checks = 0, errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit oeSeen = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] addr, input logic [7:0] data, input int nBits);
    logic [23:0] frame;
    frame = {cmd, addr, data};
    oeSeen = 1'b0;
    csN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nBits; i++) begin
      sclk = 1'b0;
      sdi  = (i < 24) ? frame[23-i] : 1'b1;
      waitClk(4);
      sclk = 1'b1;
      waitClk(4);
    end
    csN = 1'b1;
    sdi = 1'b0;
    waitClk(6);
  endtask

  task automatic readExpect(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    xfer(RD_CMD, addr, 8'h00, 24);
  endtask

  // monitor: assemble bytes seen on sdo while enabled, compare to scoreboard
  int monCnt = 0;
  logic [7:0] monByte = 8'h00;
  always @(posedge sclk or posedge csN) begin
    if (csN) monCnt = 0;
    else if (sdoOe) begin
      monByte = {monByte[6:0], sdo};
      monCnt++;
      if (monCnt == 8) begin
        monCnt = 0;
        if (expQ.size() == 0) check(1'b0, "R4 unexpected read byte", {56'h0, monByte}, 64'h0);
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(monByte == e, t, {56'h0, monByte}, {56'h0, e});
        end
      end
    end
  end

  always @(posedge clk) if (sdoOe) oeSeen = 1'b1;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] snapBuf;
    logic [7:0] snapCtl;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);

    // R1 reset state
    check({crcEn, fmtSel, ratioSel, muteN, resetN} == 8'h83, "R1 byte00 reset",
          {56'h0, crcEn, fmtSel, ratioSel, muteN, resetN}, 64'h83);
    check({validity, fsCode} == 8'h00, "R1 byte01 reset", {56'h0, validity, fsCode}, 64'h0);
    check(bufBits == '0, "R1 buffer reset", bufBits[63:0], 64'h0);
    check(sdoOe == 1'b0, "R1 sdoOe reset", {63'h0, sdoOe}, 64'h0);

    // R2 R8 write control byte 00h
    xfer(WR_CMD, 8'h00, 8'h5A, 24);
    check(!oeSeen, "R4 no enable during write", {63'h0, oeSeen}, 64'h0);
    check(crcEn == 1'b0 && fmtSel == 3'b101 && ratioSel == 2'b10 && muteN && !resetN,
          "R8 byte00 fields", {56'h0, crcEn, fmtSel, ratioSel, muteN, resetN}, 64'h5A);

    // R9 pin OR
    pinFmt = 3'b010;
    pinRatio = 2'b01;
    waitClk(1);
    check(fmtSel == 3'b111, "R9 fmt OR", {61'h0, fmtSel}, 64'h7);
    check(ratioSel == 2'b11, "R9 ratio OR", {62'h0, ratioSel}, 64'h3);
    pinFmt = 3'b000;
    pinRatio = 2'b00;

    // R8 byte 01h
    xfer(WR_CMD, 8'h01, 8'hA3, 24);
    check(validity == 4'hA && fsCode == 4'h3, "R8 byte01 fields", {56'h0, validity, fsCode}, 64'hA3);

    // R10 first and last buffer bytes
    xfer(WR_CMD, 8'h02, 8'h11, 24);
    xfer(WR_CMD, 8'h41, 8'hC7, 24);
    check(bufBits[7:0] == 8'h11, "R10 first buffer byte", {56'h0, bufBits[7:0]}, 64'h11);
    check(bufBits[511:504] == 8'hC7, "R10 last buffer byte", {56'h0, bufBits[511:504]}, 64'hC7);

    // R3 reads through scoreboard
    readExpect(8'h00, 8'h5A, "R3 read byte00");
    check(sdoOe == 1'b0, "R4 enable dropped after deselect", {63'h0, sdoOe}, 64'h0);
    readExpect(8'h01, 8'hA3, "R3 read byte01");
    readExpect(8'h41, 8'hC7, "R3 read last buffer byte");
    readExpect(8'h50, 8'h00, "R6 read out of range");

    // R6 write above range
    snapBuf = bufBits;
    snapCtl = {crcEn, fmtSel, ratioSel, muteN, resetN};
    xfer(WR_CMD, 8'h42, 8'hFF, 24);
    xfer(WR_CMD, 8'hFF, 8'hFF, 24);
    check(bufBits == snapBuf, "R6 buffer unchanged", bufBits[63:0], snapBuf[63:0]);
    check({crcEn, fmtSel, ratioSel, muteN, resetN} == snapCtl && {validity, fsCode} == 8'hA3,
          "R6 control unchanged", {56'h0, crcEn, fmtSel, ratioSel, muteN, resetN}, {56'h0, snapCtl});

    // R5 identifier mismatch
    xfer(BAD_WR, 8'h02, 8'hEE, 24);
    check(bufBits[7:0] == 8'h11, "R5 mismatch write blocked", {56'h0, bufBits[7:0]}, 64'h11);
    xfer(BAD_RD, 8'h00, 8'h00, 24);
    check(!oeSeen, "R5 mismatch read keeps sdo off", {63'h0, oeSeen}, 64'h0);

    // R7 aborted write
    xfer(WR_CMD, 8'h03, 8'h55, 20);
    check(bufBits[15:8] == 8'h00, "R7 aborted write", {56'h0, bufBits[15:8]}, 64'h0);

    // R11 extra clocks
    xfer(WR_CMD, 8'h04, 8'h3C, 30);
    check(bufBits[23:16] == 8'h3C, "R11 extra clocks ignored", {56'h0, bufBits[23:16]}, 64'h3C);
    readExpect(8'h04, 8'h3C, "R11 readback after long frame");

    waitClk(10);
    check(expQ.size() == 0, "R3 all expected bytes seen", 64'(expQ.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule